// File: doc/BRIEF.md
# Reset Vector Fetch Sequencer

This block walks a 16-bit processor through its reset exception, from the release of reset to the first instruction dispatch. It first holds the bus idle for a fixed number of idle microcycles. It then fetches four words from the bottom of memory to build the 32-bit stack pointer and the 32-bit program counter. Last, it fills a two-entry instruction prefetch queue from the new program counter, with one idle microcycle between the two fetches.

Each word read goes to a bus cycle unit as a level request. The request carries an address and a tag that marks it as a program or a data access. The request stays up until the unit answers with a one-cycle done pulse, or with a bus error. Timed idle microcycles appear as a separate idle request. When the second prefetch lands, the block raises a dispatch-ready flag for the decode stage. A bus error at any point before that parks the block in a halted state.

Top module: `reset_vector_seq`

## Requirements
- R1: From reset release, `idle_req` is high for IDLE_LONG*MC_CLKS cycles (7*2 = 14 by default) with `req_valid` low. During reset and on release, `sp`, `pc`, `pfq0` and `pfq1` are zero and `dispatch_ready` and `halted` are low.
- R2: After the long idle, exactly four data requests (`req_prog` = 0) complete, at byte addresses 0, 2, 4 and 6 in that order.
- R3: The four data words fill `sp[31:16]`, `sp[15:0]`, `pc[31:16]` and `pc[15:0]`, in that order.
- R4: A request keeps `req_valid`, `req_addr` and `req_prog` stable until a cycle in which `bus_done` or `bus_err` is sampled high. `bus_data` is taken in the cycle `bus_done` is high.
- R5: Each prefetch is a program request (`req_prog` = 1) at the current `pc[ADDR_W-1:0]`. On completion `pfq0` takes the old `pfq1` and `pfq1` takes the fetched word.
- R6: `pc` increases by 2 after each completed program fetch.
- R7: Between the first and the second prefetch, `idle_req` is high for IDLE_SHORT*MC_CLKS cycles (2 by default). No other idle time follows the vector reads.
- R8: `dispatch_ready` rises once the second prefetch completes and stays high until the next reset. From then on no request is issued.
- R9: `bus_err` sampled high before dispatch-ready sets `halted`. `halted` stays high until reset, with no further requests, no further register updates and `dispatch_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; starts the sequence on release |
| bus_done | input | 1 | One-cycle completion pulse from the bus cycle unit |
| bus_data | input | DATA_W | Read word, valid with `bus_done` |
| bus_err | input | 1 | Bus error report from the bus cycle unit |
| req_valid | output | 1 | Word read request, held until done or error |
| req_prog | output | 1 | Tag: 1 program access, 0 data access |
| req_addr | output | ADDR_W | Byte address of the requested word |
| idle_req | output | 1 | Bus idle microcycle request |
| sp | output | 32 | Stack pointer loaded from the vectors |
| pc | output | 32 | Program counter |
| pfq0 | output | DATA_W | Prefetch queue entry 0 (older word) |
| pfq1 | output | DATA_W | Prefetch queue entry 1 (newer word) |
| dispatch_ready | output | 1 | Sequence complete, decode may start |
| halted | output | 1 | Sequence stopped by a bus error |

## Verification
The assertions assume that the bus cycle unit raises `bus_done` or `bus_err` only while a request is pending. They also assume that both inputs are single-cycle pulses that are never high together. The bench bus model follows this. It answers only a visible request, after a programmable latency. It drops the pulse on the next cycle and replaces the done pulse with the error pulse when an error is injected. Latencies of zero and three cycles cover both the back-to-back path and the held-request path.

// File: rtl/rvs_pkg.sv
package rvs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE_LONG  = 3'd0,
    ST_VECTOR     = 3'd1,
    ST_PREF_A     = 3'd2,
    ST_IDLE_SHORT = 3'd3,
    ST_PREF_B     = 3'd4,
    ST_READY      = 3'd5,
    ST_HALT       = 3'd6
  } seq_state_t;

  // Byte address of vector word idx (words are two bytes apart).
  function automatic logic [31:0] vec_addr(input logic [1:0] idx);
    return {29'd0, idx, 1'b0};
  endfunction

  // Program counter after one word-sized program fetch.
  function automatic logic [31:0] pc_advance(input logic [31:0] cur);
    return cur + 32'd2;
  endfunction

endpackage

// File: rtl/rvs_idle_timer.sv
module rvs_idle_timer #(
  parameter int CW      = 4,
  parameter int RST_VAL = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          run,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt <= CW'(RST_VAL);
    else if (load)               cnt <= load_val;
    else if (run && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = run && (cnt == '0);

  AST_TIMER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val)));                       // R7
  AST_TIMER_NO_LOAD_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && run));                                           // R7
endmodule

// File: rtl/rvs_vec_regs.sv
module rvs_vec_regs
  import rvs_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [1:0]        load_sel,
  input  logic [DATA_W-1:0] word,
  input  logic              pc_inc,
  output logic [31:0]       sp,
  output logic [31:0]       pc
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp <= '0;
      pc <= '0;
    end else if (load_en) begin
      unique case (load_sel)
        2'd0: sp[31:16] <= word[15:0];
        2'd1: sp[15:0]  <= word[15:0];
        2'd2: pc[31:16] <= word[15:0];
        default: pc[15:0] <= word[15:0];
      endcase
    end else if (pc_inc) begin
      pc <= pc_advance(pc);
    end
  end

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    pc_inc |=> (pc == $past(pc) + 32'd2));                     // R6
  AST_SP_HELD_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    pc_inc |=> $stable(sp));                                   // R3
  AST_LOAD_XOR_INC: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_en && pc_inc));                                     // R3
endmodule

// File: rtl/rvs_prefetch_q.sv
module rvs_prefetch_q #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] q0,
  output logic [DATA_W-1:0] q1
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q0 <= '0;
      q1 <= '0;
    end else if (shift) begin
      q0 <= q1;
      q1 <= word;
    end
  end

  AST_QUEUE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> (q0 == $past(q1)) && (q1 == $past(word)));       // R5
  AST_QUEUE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> $stable(q0) && $stable(q1));                    // R5
endmodule

// File: rtl/reset_vector_seq.sv
module reset_vector_seq
  import rvs_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 16,
  parameter int MC_CLKS    = 2,
  parameter int IDLE_LONG  = 7,
  parameter int IDLE_SHORT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_done,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_err,
  output logic              req_valid,
  output logic              req_prog,
  output logic [ADDR_W-1:0] req_addr,
  output logic              idle_req,
  output logic [31:0]       sp,
  output logic [31:0]       pc,
  output logic [DATA_W-1:0] pfq0,
  output logic [DATA_W-1:0] pfq1,
  output logic              dispatch_ready,
  output logic              halted
);
  localparam int LONG_CLKS  = IDLE_LONG * MC_CLKS;
  localparam int SHORT_CLKS = IDLE_SHORT * MC_CLKS;
  localparam int CW         = $clog2(LONG_CLKS + 1);
  localparam logic [CW-1:0] SHORT_LOAD = CW'(SHORT_CLKS - 1);

  seq_state_t  state, state_nx;
  logic [1:0]  vidx;
  logic [31:0] vaddr_full;

  // Named internal events for the assertions.
  logic in_vector, in_prefetch, in_active, req_hit, err_hit, idle_over;
  logic vec_load, prog_fetch, short_load;

  assign in_vector   = (state == ST_VECTOR);
  assign in_prefetch = (state == ST_PREF_A) || (state == ST_PREF_B);
  assign in_active   = (state != ST_READY) && (state != ST_HALT);
  assign req_valid   = in_vector || in_prefetch;
  assign req_prog    = in_prefetch;
  assign idle_req    = (state == ST_IDLE_LONG) || (state == ST_IDLE_SHORT);
  assign vaddr_full  = vec_addr(vidx);
  assign req_addr    = in_vector ? vaddr_full[ADDR_W-1:0] : pc[ADDR_W-1:0];

  assign err_hit    = in_active && bus_err;
  assign req_hit    = req_valid && bus_done && !bus_err;
  assign vec_load   = in_vector && req_hit;
  assign prog_fetch = in_prefetch && req_hit;
  assign short_load = (state == ST_PREF_A) && req_hit;

  assign dispatch_ready = (state == ST_READY);
  assign halted         = (state == ST_HALT);

  rvs_idle_timer #(.CW(CW), .RST_VAL(LONG_CLKS - 1)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (short_load),
    .load_val(SHORT_LOAD),
    .run     (idle_req),
    .expired (idle_over)
  );

  rvs_vec_regs #(.DATA_W(DATA_W)) u_vregs (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (vec_load),
    .load_sel(vidx),
    .word    (bus_data),
    .pc_inc  (prog_fetch),
    .sp      (sp),
    .pc      (pc)
  );

  rvs_prefetch_q #(.DATA_W(DATA_W)) u_pfq (
    .clk  (clk),
    .rst_n(rst_n),
    .shift(prog_fetch),
    .word (bus_data),
    .q0   (pfq0),
    .q1   (pfq1)
  );

  always_comb begin
    state_nx = state;
    if (err_hit) begin
      state_nx = ST_HALT;
    end else begin
      unique case (state)
        ST_IDLE_LONG:  if (idle_over) state_nx = ST_VECTOR;
        ST_VECTOR:     if (req_hit && vidx == 2'd3) state_nx = ST_PREF_A;
        ST_PREF_A:     if (req_hit) state_nx = ST_IDLE_SHORT;
        ST_IDLE_SHORT: if (idle_over) state_nx = ST_PREF_B;
        ST_PREF_B:     if (req_hit) state_nx = ST_READY;
        ST_READY:      state_nx = ST_READY;
        default:       state_nx = ST_HALT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE_LONG;
      vidx  <= 2'd0;
    end else begin
      state <= state_nx;
      if (vec_load) vidx <= vidx + 2'd1;
    end
  end

  AST_IDLE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    idle_req |-> !req_valid);                                  // R1
  AST_DATA_LOW_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_prog) |-> (req_addr < ADDR_W'(8)));     // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !bus_done && !bus_err) |=>
      req_valid && $stable(req_addr) && $stable(req_prog));    // R4
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch_ready |=> dispatch_ready && !req_valid);          // R8
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && !req_valid && !dispatch_ready && $stable(pc)); // R9
  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && !dispatch_ready) |=> halted);                  // R9
endmodule

// File: tb/reset_vector_seq_test.sv
module reset_vector_seq_test;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_done = 1'b0;
  logic [DATA_W-1:0] bus_data = '0;
  logic              bus_err = 1'b0;
  logic              req_valid, req_prog, idle_req, dispatch_ready, halted;
  logic [ADDR_W-1:0] req_addr;
  logic [31:0]       sp, pc;
  logic [DATA_W-1:0] pfq0, pfq1;

  reset_vector_seq uut (
    .clk(clk), .rst_n(rst_n), .bus_done(bus_done), .bus_data(bus_data),
    .bus_err(bus_err), .req_valid(req_valid), .req_prog(req_prog),
    .req_addr(req_addr), .idle_req(idle_req), .sp(sp), .pc(pc),
    .pfq0(pfq0), .pfq1(pfq1), .dispatch_ready(dispatch_ready), .halted(halted)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Bus model settings and vector contents for the current scenario.
  int          lat = 0;
  int          err_at = -1;
  logic [15:0] vec [4];
  int          bcnt = 0;
  logic [ADDR_W-1:0] first_addr;
  logic              first_prog;

  // Completed-request log.
  int                n_log = 0;
  logic [ADDR_W-1:0] log_addr [8];
  logic              log_prog [8];

  task automatic chk(input logic ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mem(input logic [ADDR_W-1:0] a);
    if (a < 8) return vec[a[2:1]];
    return a[15:0] ^ 16'h5A5A;
  endfunction

  // Bus cycle unit model: answers after lat waiting cycles.
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_done = 1'b0; bus_err = 1'b0; bcnt = 0;
    end else if (bus_done || bus_err) begin
      bus_done = 1'b0; bus_err = 1'b0; bcnt = 0;
    end else if (req_valid) begin
      if (bcnt == 0) begin
        first_addr = req_addr; first_prog = req_prog;
      end else begin
        chk(req_addr == first_addr && req_prog == first_prog, "R4",
            "request held stable", longint'(req_addr), longint'(first_addr));
      end
      if (bcnt >= lat) begin
        if (n_log == err_at) bus_err = 1'b1;
        else begin
          bus_done = 1'b1; bus_data = mem(req_addr);
        end
      end else bcnt++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (rst_n && req_valid && bus_done && n_log < 8) begin
      log_addr[n_log] = req_addr;
      log_prog[n_log] = req_prog;
      n_log++;
    end
  end

  // Watchdog.
  always @(posedge clk) begin
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected below 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Reset and check the state at release, then measure the long idle.
  task automatic start_boot();
    int n;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    n_log = 0;
    rst_n = 1'b1;
    chk(sp == 0 && pc == 0, "R1", "sp/pc at reset", longint'(sp | pc), 0);
    chk(pfq0 == 0 && pfq1 == 0, "R1", "queue at reset", longint'(pfq0 | pfq1), 0);
    chk(!dispatch_ready && !halted, "R1", "flags at reset",
        longint'({dispatch_ready, halted}), 0);
    n = 0;
    while (idle_req && !req_valid && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk(n == 14, "R1", "long idle cycles", n, 14);
  endtask

  task automatic scen_normal(input int l, input logic [15:0] v0, input logic [15:0] v1,
                             input logic [15:0] v2, input logic [15:0] v3);
    int idles, t;
    logic [31:0] pc0;
    lat = l; err_at = -1;
    vec[0] = v0; vec[1] = v1; vec[2] = v2; vec[3] = v3;
    pc0 = {v2, v3};
    start_boot();
    idles = 0; t = 0;
    while (!dispatch_ready && t < 500) begin
      if (idle_req) idles++;
      t++;
      @(negedge clk);
    end
    chk(dispatch_ready, "R8", "ready reached", longint'(dispatch_ready), 1);
    chk(idles == 2, "R7", "short idle cycles", idles, 2);
    chk(n_log == 6, "R2", "completed requests", n_log, 6);
    for (int i = 0; i < 4; i++) begin
      chk(log_addr[i] == ADDR_W'(2 * i) && !log_prog[i], "R2", "vector read addr",
          longint'({log_prog[i], log_addr[i]}), longint'(2 * i));
    end
    chk(log_addr[4] == pc0[ADDR_W-1:0] && log_prog[4], "R5", "first prefetch",
        longint'({log_prog[4], log_addr[4]}), longint'({1'b1, pc0[ADDR_W-1:0]}));
    chk(log_addr[5] == ADDR_W'(pc0 + 2) && log_prog[5], "R6", "second prefetch addr",
        longint'({log_prog[5], log_addr[5]}), longint'({1'b1, ADDR_W'(pc0 + 2)}));
    chk(sp == {v0, v1}, "R3", "stack pointer", longint'(sp), longint'({v0, v1}));
    chk(pc == pc0 + 32'd4, "R6", "final pc", longint'(pc), longint'(pc0 + 32'd4));
    chk(pfq0 == mem(ADDR_W'(pc0)), "R5", "queue entry 0",
        longint'(pfq0), longint'(mem(ADDR_W'(pc0))));
    chk(pfq1 == mem(ADDR_W'(pc0 + 2)), "R5", "queue entry 1",
        longint'(pfq1), longint'(mem(ADDR_W'(pc0 + 2))));
    for (int i = 0; i < 10; i++) @(negedge clk);
    chk(dispatch_ready && !req_valid && !halted, "R8", "ready sticky, no requests",
        longint'({dispatch_ready, req_valid, halted}), 3'b100);
    chk(n_log == 6, "R8", "no requests after ready", n_log, 6);
  endtask

  task automatic scen_error(input int l, input int at);
    int t;
    logic [31:0] pc_h;
    lat = l; err_at = at;
    vec[0] = 16'h0001; vec[1] = 16'h2000; vec[2] = 16'h0000; vec[3] = 16'h0400;
    start_boot();
    t = 0;
    while (!halted && t < 500) begin
      t++;
      @(negedge clk);
    end
    pc_h = pc;
    chk(halted && !dispatch_ready, "R9", "halted after error",
        longint'({halted, dispatch_ready}), 2'b10);
    chk(n_log == at, "R9", "requests before error", n_log, at);
    for (int i = 0; i < 10; i++) begin
      chk(!req_valid, "R9", "no request while halted", longint'(req_valid), 0);
      @(negedge clk);
    end
    chk(halted && !dispatch_ready && pc == pc_h && n_log == at, "R9",
        "halt sticky, pc frozen", longint'(pc), longint'(pc_h));
  endtask

  initial begin
    vec[0] = 0; vec[1] = 0; vec[2] = 0; vec[3] = 0;
    scen_normal(0, 16'h00AB, 16'hCDEF, 16'h0000, 16'h1230);
    scen_normal(3, 16'hFFFE, 16'h0010, 16'h0012, 16'h8008);
    scen_error(1, 2);
    scen_error(2, 4);
    scen_normal(1, 16'h1357, 16'h9BDF, 16'h00FF, 16'hFFFC);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule